// File: doc/BRIEF.md
# Long-Mode Interrupt Gate Fetch and Validate Sequencer

This block turns an interrupt vector into a checked handler target. When a vector is accepted, it reads the two 64-bit halves of the 16-byte gate entry from the interrupt table. It then checks the gate type. Using the selector held in the gate, it reads the 8-byte code-segment descriptor from either the local or the global descriptor table. Before it reports success, it checks that the assembled 64-bit handler address is canonical.

Memory is reached through a simple read port. The request channel uses a valid/ready handshake, and at most one read is in flight at a time. Each run ends in one of two one-cycle pulses. The first is `done`, which comes with a result bundle: handler address, code selector, code descriptor and stack-table index. The second is `fault`, which stands for a general-protection fault whose error code is always zero. The privilege check is done outside the block, and its verdict enters on `priv_fail`.

Top module: `intgate_fetch`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `fault` and `rd_req_valid` are all low.
- R2: For vector v, the first read is at `idt_base + 16*v` and the second at `idt_base + 16*v + 8`. A request holds its valid and address until ready is seen, and only one read is outstanding at a time.
- R3: If the low gate word's bits 43:40 ANDed with 0xE differ from 0xE, the run ends in `fault` and no code-descriptor read is issued (for example, type 0xC faults and types 0xE and 0xF pass).
- R4: The selector is low-word bits 31:16, and the table index is the selector ANDed with 0xF8. Selector bit 2 set reads `ldt_base + index`. Selector bit 2 clear reads `gdt_base + index`.
- R5: The handler address takes bits 15:0 from low-word bits 15:0, bits 31:16 from low-word bits 63:48, and bits 63:32 from high-word bits 31:0.
- R6: A handler address whose bits 63:47 are not all equal ends the run in `fault` after the code-descriptor read. An address with all-zero or all-one upper bits is accepted.
- R7: `priv_fail`, sampled when the high gate word and when the code descriptor return, forces `fault`.
- R8: On `done`, `cs_sel` is the gate selector, `cs_desc` is the code descriptor read, and `ist_idx` is gate bits 34:32.
- R9: `busy` is high from vector acceptance until the ending pulse. A vector presented while busy is ignored and starts no reads.
- R10: `done` and `fault` are one-cycle pulses and are never high together. Exactly one of them ends each run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_valid | input | 1 | Vector presented |
| vec_num | input | 8 | Interrupt vector |
| idt_base | input | 64 | Interrupt table base |
| gdt_base | input | 64 | Global descriptor table base |
| ldt_base | input | 64 | Local descriptor table base |
| priv_fail | input | 1 | External privilege check verdict |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data quadword |
| busy | output | 1 | Run in progress |
| done | output | 1 | Success pulse |
| fault | output | 1 | General-protection fault pulse (error code 0) |
| hdl_addr | output | 64 | Handler target address |
| cs_sel | output | 16 | Code-segment selector |
| cs_desc | output | 64 | Code-segment descriptor |
| ist_idx | output | 3 | Stack-table index from the gate |

## Verification
The assertions assume the memory side follows the handshake. This means a response arrives only while a read is outstanding, and it arrives exactly once per accepted request. The bench memory model meets this assumption. It records each accepted request, returns data on the following cycle, and stays silent otherwise. The model also inserts ready stalls so that the request-hold property is exercised. The bases and `priv_fail` are changed only between runs.

// File: rtl/igf_pkg.sv
package igf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ_LO  = 3'd1,
        ST_WAIT_LO = 3'd2,
        ST_REQ_HI  = 3'd3,
        ST_WAIT_HI = 3'd4,
        ST_REQ_CS  = 3'd5,
        ST_WAIT_CS = 3'd6
    } igf_state_e;

    localparam int QW_W       = 64;
    localparam int QW_BYTES   = 8;
    localparam int GATE_SHIFT = 4;
    localparam int TYPE_LSB   = 40;
    localparam int SEL_LSB    = 16;
    localparam int IST_LSB    = 32;
    localparam int TI_BIT     = 2;
    localparam logic [3:0] TYPE_MASK = 4'hE;
    localparam logic [7:0] IDX_MASK  = 8'hF8;
endpackage

// File: rtl/igf_gate_decode.sv
module igf_gate_decode
    import igf_pkg::*;
(
    input  logic [QW_W-1:0] gate_lo,
    input  logic [QW_W-1:0] gate_hi,
    output logic            type_ok,
    output logic [15:0]     sel,
    output logic            sel_local,
    output logic [7:0]      sel_index,
    output logic [QW_W-1:0] target,
    output logic [2:0]      ist
);
    logic [3:0] gtype;

    always_comb begin
        gtype     = gate_lo[TYPE_LSB +: 4];
        type_ok   = (gtype & TYPE_MASK) == TYPE_MASK;
        sel       = gate_lo[SEL_LSB +: 16];
        sel_local = sel[TI_BIT];
        sel_index = sel[7:0] & IDX_MASK;
        target    = {gate_hi[31:0], gate_lo[63:48], gate_lo[15:0]};
        ist       = gate_lo[IST_LSB +: 3];
    end
endmodule

// File: rtl/igf_canon_chk.sv
module igf_canon_chk #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ok
);
    localparam int HI_W = ADDR_W - VA_BITS + 1;

    logic [HI_W-1:0] upper;

    always_comb begin
        upper = addr[ADDR_W-1:VA_BITS-1];
        ok    = (&upper) | ~(|upper);
    end
endmodule

// File: rtl/intgate_fetch.sv
module intgate_fetch
    import igf_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int VEC_W   = 8,
    parameter int VA_BITS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [ADDR_W-1:0] idt_base,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic              priv_fail,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [QW_W-1:0]   rd_rsp_data,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [QW_W-1:0]   hdl_addr,
    output logic [15:0]       cs_sel,
    output logic [QW_W-1:0]   cs_desc,
    output logic [2:0]        ist_idx
);
    typedef struct packed {
        igf_state_e        st;
        logic [VEC_W-1:0]  vec;
        logic [QW_W-1:0]   lo;
        logic [QW_W-1:0]   hi;
        logic [QW_W-1:0]   cd;
        logic              done;
        logic              fault;
    } igf_regs_t;

    igf_regs_t r_q, r_d;

    logic            type_ok, sel_local, canon_ok;
    logic [7:0]      sel_index;
    logic [QW_W-1:0] target;
    logic [ADDR_W-1:0] gate_addr;

    igf_gate_decode u_dec (
        .gate_lo   (r_q.lo),
        .gate_hi   (r_q.hi),
        .type_ok   (type_ok),
        .sel       (cs_sel),
        .sel_local (sel_local),
        .sel_index (sel_index),
        .target    (target),
        .ist       (ist_idx)
    );

    igf_canon_chk #(.ADDR_W(QW_W), .VA_BITS(VA_BITS)) u_canon (
        .addr (target),
        .ok   (canon_ok)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (vec_valid) begin
                r_d.vec = vec_num;
                r_d.st  = ST_REQ_LO;
            end
            ST_REQ_LO: if (rd_req_ready) r_d.st = ST_WAIT_LO;
            ST_WAIT_LO: if (rd_rsp_valid) begin
                r_d.lo = rd_rsp_data;
                r_d.st = ST_REQ_HI;
            end
            ST_REQ_HI: if (rd_req_ready) r_d.st = ST_WAIT_HI;
            ST_WAIT_HI: if (rd_rsp_valid) begin
                r_d.hi = rd_rsp_data;
                if (priv_fail || !type_ok) begin
                    r_d.fault = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.st = ST_REQ_CS;
                end
            end
            ST_REQ_CS: if (rd_req_ready) r_d.st = ST_WAIT_CS;
            ST_WAIT_CS: if (rd_rsp_valid) begin
                r_d.cd = rd_rsp_data;
                r_d.st = ST_IDLE;
                if (priv_fail || !canon_ok) r_d.fault = 1'b1;
                else                        r_d.done  = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        gate_addr    = idt_base + (ADDR_W'(r_q.vec) << GATE_SHIFT);
        rd_req_valid = (r_q.st == ST_REQ_LO) || (r_q.st == ST_REQ_HI) ||
                       (r_q.st == ST_REQ_CS);
        unique case (r_q.st)
            ST_REQ_HI: rd_req_addr = gate_addr + ADDR_W'(QW_BYTES);
            ST_REQ_CS: rd_req_addr = (sel_local ? ldt_base : gdt_base) +
                                     ADDR_W'(sel_index);
            default:   rd_req_addr = gate_addr;
        endcase
        busy     = r_q.st != ST_IDLE;
        done     = r_q.done;
        fault    = r_q.fault;
        hdl_addr = target;
        cs_desc  = r_q.cd;
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R9
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req_valid);

    // R6
    done_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> canon_ok);

    // R3
    done_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> type_ok);
endmodule

// File: tb/tb_intgate_fetch.sv
module tb_intgate_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_valid = 1'b0;
    logic [7:0]  vec_num = '0;
    logic [63:0] idt_base = 64'h1000;
    logic [63:0] gdt_base = 64'h20000;
    logic [63:0] ldt_base = 64'h30000;
    logic        priv_fail = 1'b0;
    logic        rd_req_valid, rd_req_ready;
    logic [63:0] rd_req_addr;
    logic        rd_rsp_valid;
    logic [63:0] rd_rsp_data;
    logic        busy, done, fault;
    logic [63:0] hdl_addr, cs_desc;
    logic [15:0] cs_sel;
    logic [2:0]  ist_idx;

    intgate_fetch dut (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_num(vec_num),
        .idt_base(idt_base), .gdt_base(gdt_base), .ldt_base(ldt_base),
        .priv_fail(priv_fail), .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .busy(busy), .done(done), .fault(fault), .hdl_addr(hdl_addr),
        .cs_sel(cs_sel), .cs_desc(cs_desc), .ist_idx(ist_idx)
    );

    always #2 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] rd_log [8];
    int rd_cnt = 0;
    int stall_cfg = 0;
    int stall_left = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'hBAD0_BAD0_BAD0_BAD0;
    endfunction

    task automatic put_gate(input logic [7:0] v, input logic [63:0] off,
                            input logic [15:0] sel, input logic [3:0] typ,
                            input logic [2:0] ist);
        logic [63:0] a;
        a = idt_base + {52'd0, v, 4'd0};
        mem[a]     = {off[31:16], 4'h8, typ, 5'd0, ist, sel, off[15:0]};
        mem[a + 8] = {32'd0, off[63:32]};
    endtask

    // memory model: one response per accepted request, on the next cycle
    initial begin
        logic        pend;
        logic [63:0] pend_addr;
        pend = 1'b0;
        pend_addr = '0;
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = '0;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if (pend) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem_rd(pend_addr);
                pend = 1'b0;
            end
            rd_req_ready = 1'b0;
            if (rd_req_valid) begin
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    rd_req_ready = 1'b1;
                    pend = 1'b1;
                    pend_addr = rd_req_addr;
                    if (rd_cnt < 8) rd_log[rd_cnt] = rd_req_addr;
                    rd_cnt++;
                    stall_left = stall_cfg;
                end
            end
        end
    end

    task automatic run_vec(input logic [7:0] v, output bit got_done,
                           output bit got_fault);
        rd_cnt = 0;
        stall_left = stall_cfg;
        @(negedge clk);
        vec_valid = 1'b1;
        vec_num = v;
        @(negedge clk);
        vec_valid = 1'b0;
        got_done = 1'b0;
        got_fault = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done || fault) begin
                got_done = done;
                got_fault = fault;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(!busy, "R1 busy", 64'(busy), 0);
        chk(!done && !fault, "R1 pulses", 64'({done, fault}), 0);
        chk(!rd_req_valid, "R1 req", 64'(rd_req_valid), 0);
    endtask

    task automatic t_global_ok();
        bit d, f;
        put_gate(8'h21, 64'h0000_1234_5678_9ABC, 16'h0010, 4'hE, 3'd0);
        mem[64'h20010] = 64'h00AF_9A00_0000_FFFF;
        run_vec(8'h21, d, f);
        chk(d && !f, "R10 done", 64'({d, f}), 64'b10);
        chk(rd_cnt == 3, "R2 reads", 64'(rd_cnt), 3);
        chk(rd_log[0] == 64'h1210, "R2 lo addr", rd_log[0], 64'h1210);
        chk(rd_log[1] == 64'h1218, "R2 hi addr", rd_log[1], 64'h1218);
        chk(rd_log[2] == 64'h20010, "R4 gdt addr", rd_log[2], 64'h20010);
        chk(hdl_addr == 64'h0000_1234_5678_9ABC, "R5 target", hdl_addr,
            64'h0000_1234_5678_9ABC);
        chk(cs_sel == 16'h0010, "R8 sel", 64'(cs_sel), 64'h10);
        chk(cs_desc == 64'h00AF_9A00_0000_FFFF, "R8 desc", cs_desc,
            64'h00AF_9A00_0000_FFFF);
        chk(ist_idx == 3'd0, "R8 ist", 64'(ist_idx), 0);
        @(negedge clk);
        chk(!done && !fault, "R10 pulse width", 64'({done, fault}), 0);
    endtask

    task automatic t_local_stall();
        bit d, f;
        stall_cfg = 2;
        put_gate(8'hFF, 64'hFFFF_8000_0000_1000, 16'h002C, 4'hF, 3'd5);
        mem[64'h30028] = 64'h0020_9B00_0000_0000;
        run_vec(8'hFF, d, f);
        stall_cfg = 0;
        chk(d && !f, "R6 upper-ones done", 64'({d, f}), 64'b10);
        chk(rd_log[0] == 64'h1FF0 && rd_log[1] == 64'h1FF8, "R2 stall addrs",
            rd_log[0], 64'h1FF0);
        chk(rd_log[2] == 64'h30028, "R4 ldt addr", rd_log[2], 64'h30028);
        chk(hdl_addr == 64'hFFFF_8000_0000_1000, "R5 high target", hdl_addr,
            64'hFFFF_8000_0000_1000);
        chk(ist_idx == 3'd5, "R8 ist5", 64'(ist_idx), 5);
        chk(cs_desc == 64'h0020_9B00_0000_0000, "R8 ldt desc", cs_desc,
            64'h0020_9B00_0000_0000);
    endtask

    task automatic t_bad_type();
        bit d, f;
        put_gate(8'h03, 64'h1000, 16'h0008, 4'hC, 3'd0);
        run_vec(8'h03, d, f);
        chk(f && !d, "R3 type fault", 64'({d, f}), 64'b01);
        chk(rd_cnt == 2, "R3 no cs read", 64'(rd_cnt), 2);
    endtask

    task automatic t_noncanon();
        bit d, f;
        put_gate(8'h04, 64'h0000_8000_0000_0000, 16'h0008, 4'hE, 3'd0);
        mem[64'h20008] = 64'h1;
        run_vec(8'h04, d, f);
        chk(f && !d, "R6 noncanon fault", 64'({d, f}), 64'b01);
        chk(rd_cnt == 3, "R6 cs read first", 64'(rd_cnt), 3);
    endtask

    task automatic t_canon_edge();
        bit d, f;
        put_gate(8'h05, 64'h0000_7FFF_FFFF_FFFF, 16'h0008, 4'hE, 3'd0);
        run_vec(8'h05, d, f);
        chk(d && !f, "R6 top low canonical", 64'({d, f}), 64'b10);
        chk(hdl_addr == 64'h0000_7FFF_FFFF_FFFF, "R5 edge target", hdl_addr,
            64'h0000_7FFF_FFFF_FFFF);
    endtask

    task automatic t_priv();
        bit d, f;
        priv_fail = 1'b1;
        run_vec(8'h21, d, f);
        priv_fail = 1'b0;
        chk(f && !d, "R7 priv fault", 64'({d, f}), 64'b01);
        chk(rd_cnt == 2, "R7 at gate", 64'(rd_cnt), 2);
    endtask

    task automatic t_sel_mask();
        bit d, f;
        put_gate(8'h06, 64'h4000, 16'h12B3, 4'hE, 3'd7);
        mem[64'h200B0] = 64'h5555;
        run_vec(8'h06, d, f);
        chk(d, "R4 mask done", 64'(d), 1);
        chk(rd_log[2] == 64'h200B0, "R4 masked idx", rd_log[2], 64'h200B0);
        chk(cs_sel == 16'h12B3, "R8 full sel", 64'(cs_sel), 64'h12B3);
        chk(ist_idx == 3'd7, "R8 ist7", 64'(ist_idx), 7);
    endtask

    task automatic t_busy();
        bit seen_done;
        rd_cnt = 0;
        @(negedge clk);
        vec_valid = 1'b1;
        vec_num = 8'h21;
        @(negedge clk);
        vec_num = 8'h06;
        chk(busy, "R9 busy", 64'(busy), 1);
        seen_done = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (i == 3) vec_valid = 1'b0;
            if (done) begin
                seen_done = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(seen_done, "R9 finished", 64'(seen_done), 1);
        chk(rd_log[0] == 64'h1210, "R9 first vector kept", rd_log[0], 64'h1210);
        repeat (3) @(negedge clk);
        chk(rd_cnt == 3 && !busy, "R9 ignored vector", 64'(rd_cnt), 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global_ok();
        t_local_stall();
        t_bad_type();
        t_noncanon();
        t_canon_edge();
        t_priv();
        t_sel_mask();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule